// File: doc/BRIEF.md
# Dual-Lane Booth Multiplier (16-bit / 2×8-bit)

This combinational multiplier takes two 16-bit operands and produces a 32-bit result in one of two shapes. In whole-word mode it returns one 16×16 product. In split mode each operand is treated as two independent bytes, and the result holds two 16-bit byte products side by side. A second select picks signed (two's complement) or unsigned interpretation. The setting applies to the whole word, or to both lanes at once.

Internally two 16×8 sub-multipliers share the multiplicand and each takes one byte of the multiplier. Before recoding, each multiplier byte is widened by one bit and the multiplicand is sign- or zero-extended. This lets each sub-multiplier act either as one half of the 16×16 product or as a standalone 8×8 lane. Each sub-multiplier forms radix-4 Booth partial products and compresses them with two levels of 4-2 compressors. A Kogge-Stone prefix adder resolves each result. In whole-word mode a third prefix adder adds the upper half-product, shifted left by 8, to the lower one.

Top module: `smul_simd_mult`

## Requirements
- R1: With split_i=0 and sgn_i=1, p_o equals the 32-bit two's-complement product of a_i and b_i, both read as signed 16-bit values.
- R2: With split_i=0 and sgn_i=0, p_o equals the 32-bit product of a_i and b_i, both read as unsigned 16-bit values.
- R3: With split_i=1 and sgn_i=1, p_o[15:0] is the signed product a_i[7:0]×b_i[7:0] and p_o[31:16] is the signed product a_i[15:8]×b_i[15:8], each as a 16-bit two's-complement value.
- R4: With split_i=1 and sgn_i=0, p_o[15:0] and p_o[31:16] are the unsigned byte products of the same byte pairs as in R3.
- R5: In split mode no carry or sign crosses between lanes. p_o[31:16] depends only on the upper bytes, and p_o[15:0] depends only on the lower bytes.
- R6: Extreme operands produce exact results. Signed 0x8000×0x8000 gives 0x40000000, signed 0x8000×0x7FFF gives 0xC0008000, and unsigned 0xFFFF×0xFFFF gives 0xFFFE0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | Multiplicand (whole word, or two byte lanes) |
| b_i | input | 16 | Multiplier (whole word, or two byte lanes) |
| split_i | input | 1 | 1: two independent 8×8 lanes; 0: one 16×16 product |
| sgn_i | input | 1 | 1: operands are two's complement; 0: unsigned |
| p_o | output | 32 | Product, or {upper lane product, lower lane product} |

## Verification
In split mode both lane products are formed in the same evaluation by the two sub-multipliers. Each has its own Booth digits and its own negative-row corrections, so an error in lane isolation shows up only when both lanes are busy at once. The exhaustive byte sweep therefore drives a different, moving pattern into the upper lane while the lower lane walks all 65,536 byte pairs, in each signedness. Each half of p_o is judged separately against a product computed arithmetically. Directed cases also place the extreme byte products in one lane while the other lane is zero, to expose any carry that leaks across the lane boundary.

// File: rtl/smul_pkg.sv
package smul_pkg;
  parameter int unsigned LANE_W = 8;
  localparam int unsigned FULL_W = 2 * LANE_W;
  localparam int unsigned MC_W   = FULL_W + 1;          // multiplicand with extension bit
  localparam int unsigned LO_W   = MC_W + LANE_W + 1;   // lower half-product, full signed range
  localparam int unsigned HI_W   = FULL_W + LANE_W;     // upper half-product, only bits kept after shift
  localparam int unsigned OUT_W  = 2 * FULL_W;
endpackage

// File: rtl/smul_csa42.sv
module smul_csa42 #(
  parameter int unsigned W = 26
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);
  logic [W-1:0] t;
  logic [W-2:0] k;
  logic [W-2:0] cm;

  always_comb begin
    for (int i = 0; i < W; i++) t[i] = a_i[i] ^ b_i[i] ^ c_i[i];
    for (int i = 0; i < W - 1; i++)
      k[i] = (a_i[i] & b_i[i]) | (a_i[i] & c_i[i]) | (b_i[i] & c_i[i]);
    s_o[0] = t[0] ^ d_i[0];
    cm[0]  = t[0] & d_i[0];
    for (int i = 1; i < W; i++) s_o[i] = t[i] ^ d_i[i] ^ k[i-1];
    for (int i = 1; i < W - 1; i++)
      cm[i] = (t[i] & d_i[i]) | (t[i] & k[i-1]) | (d_i[i] & k[i-1]);
    c_o = {cm, 1'b0};
  end
endmodule

// File: rtl/smul_ks_add.sv
module smul_ks_add #(
  parameter int unsigned W = 26
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  always_comb begin
    logic [W-2:0] g;
    logic [W-2:0] p;
    g = a_i[W-2:0] & b_i[W-2:0];
    p = a_i[W-2:0] ^ b_i[W-2:0];
    // descending index keeps the previous level visible below i
    for (int d = 1; d < W - 1; d = d * 2)
      for (int i = W - 2; i >= d; i--) begin
        g[i] = g[i] | (p[i] & g[i-d]);
        p[i] = p[i] & p[i-d];
      end
    s_o = a_i ^ b_i ^ {g, 1'b0};
  end
endmodule

// File: rtl/smul_booth_rows.sv
module smul_booth_rows #(
  parameter int unsigned MC_W = 17,
  parameter int unsigned MP_W = 8,
  parameter int unsigned W    = 26,
  localparam int unsigned NDIG = (MP_W + 2) / 2,
  localparam int unsigned NROW = NDIG + 1
) (
  input  logic [MC_W-1:0]          mcand_i,
  input  logic [MP_W-1:0]          mplr_i,
  input  logic                     mext_i,
  output logic [NROW-1:0][W-1:0]   rows_o
);
  always_comb begin
    logic [2*NDIG:0] y;
    logic [W-1:0]    xs, mag;
    logic [2:0]      trio;
    logic            one, two, neg;
    y  = {{(2*NDIG-MP_W){mext_i}}, mplr_i, 1'b0};
    xs = {{(W-MC_W){mcand_i[MC_W-1]}}, mcand_i};
    rows_o = '0;
    for (int d = 0; d < NDIG; d++) begin
      trio = y[2*d+2 -: 3];
      one  = trio[1] ^ trio[0];
      two  = (trio == 3'b011) || (trio == 3'b100);
      neg  = trio[2] & ~(trio[1] & trio[0]);
      mag  = one ? xs : (two ? (xs << 1) : '0);
      rows_o[d] = (neg ? ~mag : mag) << (2 * d);
      rows_o[NDIG][2*d] = neg;  // +1 completing the one's complement
    end
  end
endmodule

// File: rtl/smul_sub.sv
module smul_sub #(
  parameter int unsigned MC_W = 17,
  parameter int unsigned MP_W = 8,
  parameter int unsigned W    = 26
) (
  input  logic [MC_W-1:0] mcand_i,
  input  logic [MP_W-1:0] mplr_i,
  input  logic            mext_i,
  output logic [W-1:0]    prod_o
);
  localparam int unsigned NROW = (MP_W + 2) / 2 + 1;

  logic [NROW-1:0][W-1:0] rows;
  logic [W-1:0] s1, c1, s2, c2;

  smul_booth_rows #(.MC_W(MC_W), .MP_W(MP_W), .W(W)) u_rows (
    .mcand_i(mcand_i), .mplr_i(mplr_i), .mext_i(mext_i), .rows_o(rows)
  );

  // six rows: two 4-2 levels leave one sum/carry pair
  smul_csa42 #(.W(W)) u_lvl0 (
    .a_i(rows[0]), .b_i(rows[1]), .c_i(rows[2]), .d_i(rows[3]), .s_o(s1), .c_o(c1)
  );
  smul_csa42 #(.W(W)) u_lvl1 (
    .a_i(s1), .b_i(c1), .c_i(rows[4]), .d_i(rows[5]), .s_o(s2), .c_o(c2)
  );

  smul_ks_add #(.W(W)) u_cpa (.a_i(s2), .b_i(c2), .s_o(prod_o));
endmodule

// File: rtl/smul_simd_mult.sv
module smul_simd_mult
  import smul_pkg::*;
(
  input  logic [FULL_W-1:0] a_i,
  input  logic [FULL_W-1:0] b_i,
  input  logic              split_i,
  input  logic              sgn_i,
  output logic [OUT_W-1:0]  p_o
);
  logic [MC_W-1:0]  lo_mc, hi_mc;
  logic             lo_ext, hi_ext;
  logic [LO_W-1:0]  lo_p;
  logic [HI_W-1:0]  hi_p;
  logic [OUT_W-1:0] full_p;

  always_comb begin
    if (split_i) begin
      lo_mc  = {{(MC_W-LANE_W){sgn_i & a_i[LANE_W-1]}}, a_i[LANE_W-1:0]};
      hi_mc  = {{(MC_W-LANE_W){sgn_i & a_i[FULL_W-1]}}, a_i[FULL_W-1:LANE_W]};
      lo_ext = sgn_i & b_i[LANE_W-1];
    end else begin
      lo_mc  = {sgn_i & a_i[FULL_W-1], a_i};
      hi_mc  = lo_mc;
      lo_ext = 1'b0;  // low multiplier byte is magnitude only
    end
    hi_ext = sgn_i & b_i[FULL_W-1];
  end

  smul_sub #(.MC_W(MC_W), .MP_W(LANE_W), .W(LO_W)) u_lo (
    .mcand_i(lo_mc), .mplr_i(b_i[LANE_W-1:0]), .mext_i(lo_ext), .prod_o(lo_p)
  );
  smul_sub #(.MC_W(MC_W), .MP_W(LANE_W), .W(HI_W)) u_hi (
    .mcand_i(hi_mc), .mplr_i(b_i[FULL_W-1:LANE_W]), .mext_i(hi_ext), .prod_o(hi_p)
  );

  smul_ks_add #(.W(OUT_W)) u_join (
    .a_i({{(OUT_W-LO_W){lo_p[LO_W-1]}}, lo_p}),
    .b_i({hi_p, {LANE_W{1'b0}}}),
    .s_o(full_p)
  );

  assign p_o = split_i ? {hi_p[FULL_W-1:0], lo_p[FULL_W-1:0]} : full_p;
endmodule

// File: rtl/smul_simd_mult_chk.sv
module smul_simd_mult_chk (
  input logic [15:0] a_i,
  input logic [15:0] b_i,
  input logic        split_i,
  input logic        sgn_i,
  input logic [31:0] p_o
);
  always_comb begin
    logic signed [31:0] ws_a, ws_b;
    logic signed [15:0] ls_a, ls_b, hs_a, hs_b;
    logic [31:0] ref_s, ref_u;
    logic [15:0] lo_s, lo_u, hi_s, hi_u;
    ws_a  = {{16{a_i[15]}}, a_i};
    ws_b  = {{16{b_i[15]}}, b_i};
    ref_s = 32'(ws_a * ws_b);
    ref_u = {16'b0, a_i} * {16'b0, b_i};
    ls_a  = {{8{a_i[7]}}, a_i[7:0]};
    ls_b  = {{8{b_i[7]}}, b_i[7:0]};
    hs_a  = {{8{a_i[15]}}, a_i[15:8]};
    hs_b  = {{8{b_i[15]}}, b_i[15:8]};
    lo_s  = 16'(ls_a * ls_b);
    hi_s  = 16'(hs_a * hs_b);
    lo_u  = {8'b0, a_i[7:0]} * {8'b0, b_i[7:0]};
    hi_u  = {8'b0, a_i[15:8]} * {8'b0, b_i[15:8]};
    // R1
    full_signed_chk: assert (split_i || !sgn_i || p_o == ref_s);
    // R2
    full_unsigned_chk: assert (split_i || sgn_i || p_o == ref_u);
    // R3
    lane_signed_chk: assert (!split_i || !sgn_i || p_o == {hi_s, lo_s});
    // R4
    lane_unsigned_chk: assert (!split_i || sgn_i || p_o == {hi_u, lo_u});
    // R6
    min_square_chk: assert (split_i || !sgn_i || a_i != 16'h8000 || b_i != 16'h8000
                            || p_o == 32'h4000_0000);
  end
endmodule

bind smul_simd_mult smul_simd_mult_chk u_chk (.*);

// File: tb/tb_smul_simd_mult.sv
module tb_smul_simd_mult;
  logic        clk = 1'b0;
  logic [15:0] a, b;
  logic        split, sgn;
  logic [31:0] p;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  smul_simd_mult dut (.a_i(a), .b_i(b), .split_i(split), .sgn_i(sgn), .p_o(p));

  function automatic logic [31:0] ref16(input logic [15:0] x, y, input logic s);
    logic signed [31:0] xe, ye;
    xe = s ? {{16{x[15]}}, x} : {16'b0, x};
    ye = s ? {{16{y[15]}}, y} : {16'b0, y};
    return 32'(xe * ye);
  endfunction

  function automatic logic [15:0] ref8(input logic [7:0] x, y, input logic s);
    logic signed [15:0] xe, ye;
    xe = s ? {{8{x[7]}}, x} : {8'b0, x};
    ye = s ? {{8{y[7]}}, y} : {8'b0, y};
    return 16'(xe * ye);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h (a=%h b=%h split=%0b sgn=%0b)", tag, act, exp, a, b, split, sgn);
    end
  endtask

  task automatic apply(input logic [15:0] xa, xb, input logic sp, sg);
    @(negedge clk);
    a = xa; b = xb; split = sp; sgn = sg;
    #2;
  endtask

  initial begin
    a = '0; b = '0; split = 1'b0; sgn = 1'b0;
    apply(16'h0, 16'h0, 1'b0, 1'b1);
    chk("R1 zero", p, 32'h0);

    // R3 / R4: exhaustive lower lane, moving pattern in upper lane
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 256; i++)
        for (int j = 0; j < 256; j++) begin
          logic [7:0] ah, bh;
          ah = 8'(i * 7 + 3);
          bh = 8'(j) ^ 8'hA5;
          apply({ah, 8'(i)}, {bh, 8'(j)}, 1'b1, s[0]);
          chk(s[0] ? "R3 lo" : "R4 lo", {16'b0, p[15:0]}, {16'b0, ref8(8'(i), 8'(j), s[0])});
          chk(s[0] ? "R3 hi" : "R4 hi", {16'b0, p[31:16]}, {16'b0, ref8(ah, bh, s[0])});
        end

    // R1 / R2: random whole-word operands
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 3000; k++) begin
        logic [15:0] ra, rb;
        ra = 16'($urandom);
        rb = 16'($urandom);
        apply(ra, rb, 1'b0, s[0]);
        chk(s[0] ? "R1" : "R2", p, ref16(ra, rb, s[0]));
      end

    // R6: extremes
    apply(16'h8000, 16'h8000, 1'b0, 1'b1); chk("R6 min*min", p, 32'h4000_0000);
    apply(16'h8000, 16'h7FFF, 1'b0, 1'b1); chk("R6 min*max", p, 32'hC000_8000);
    apply(16'hFFFF, 16'hFFFF, 1'b0, 1'b0); chk("R6 ffff^2 u", p, 32'hFFFE_0001);
    apply(16'hFFFF, 16'hFFFF, 1'b0, 1'b1); chk("R1 -1*-1", p, 32'h0000_0001);
    apply(16'h00FF, 16'h0100, 1'b0, 1'b0); chk("R2 cross byte", p, 32'h0000_FF00);

    // R5: lane isolation
    apply(16'h0080, 16'h0080, 1'b1, 1'b1); chk("R5 lo only s", p, 32'h0000_4000);
    apply(16'h00FF, 16'h00FF, 1'b1, 1'b0); chk("R5 lo only u", p, 32'h0000_FE01);
    apply(16'hFF00, 16'hFF00, 1'b1, 1'b0); chk("R5 hi only u", p, 32'hFE01_0000);
    apply(16'h80FF, 16'h7F01, 1'b1, 1'b1); chk("R5 mixed s", p, 32'hC080_FFFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule